// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds received serial bytes for a host in a 16-entry first-in first-out queue, or, when queueing is switched off, in a single holding register. It owns the control byte that turns queueing on, picks the interrupt threshold and issues queue resets. It also keeps the receive side of the line status: data ready, overrun and break. A receiver feeds it whole bytes and break events. The host pops bytes through a buffer read and clears the sticky error flags through a status read.

An interrupt unit reads two flags from the block. The first says the queue holds at least the selected number of bytes. The second says data has sat in the queue for four character times with no activity. The length of one character time, in clock cycles, is an input. When queueing is turned on or off, both the receive and the transmit queues are flushed. The transmit flush leaves the block as a one-cycle pulse.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the level is 0; data ready, overrun, break, timeout, trigger and transmit flush are all 0; the control value is 0x00, so queueing is off.
- R2: With queueing on (control bit 0 = 1), up to 16 bytes are kept in arrival order. `rd_data` shows the oldest byte, and a buffer read removes it.
- R3: A byte that arrives while 16 are stored is dropped. Stored data is unchanged and overrun is set.
- R4: Control bits [7:6] set the threshold: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 bytes. With queueing on, `trig_hit` is 1 when data ready is set and the level is at or above the threshold. With queueing off, `trig_hit` equals data ready.
- R5: A control write keeps only bits 7, 6, 3 and 0. Bit 1 clears the receive queue: its contents, pointers, data ready, break and pending timeout. Bit 2 gives a one-cycle `tx_flush` pulse. A write whose value equals the held control value changes nothing and gives no pulse.
- R6: A control write that changes bit 0 forces both the receive clear and the `tx_flush` pulse.
- R7: With queueing on, a timer of 4×`char_time` cycles restarts on each received byte and on each buffer read that leaves data in the queue. If it expires while data is present, `tmo_pend` is set. A buffer read clears it. `tmo_pend` is never set while the queue is empty.
- R8: A buffer read that empties the queue clears data ready and break.
- R9: A break event stores a 0x00 byte and sets both break and data ready.
- R10: A status read clears break and overrun and leaves data ready as it is.
- R11: With queueing off, one holding register keeps the newest byte. A byte that arrives while data ready is set raises overrun. A buffer read clears data ready.
- R12: A buffer read of an empty queue returns 0x00 and leaves the level at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break event this cycle |
| fcr_we | input | 1 | Control write strobe |
| fcr_wdata | input | 8 | Control write value |
| rbr_rd | input | 1 | Buffer read strobe (pops one byte) |
| lsr_rd | input | 1 | Status read strobe |
| char_time | input | CT_W | Cycles per character |
| rd_data | output | 8 | Oldest byte, or 0x00 when the queue is empty |
| data_ready | output | 1 | Data ready flag |
| overrun_err | output | 1 | Overrun flag |
| break_seen | output | 1 | Break flag |
| trig_hit | output | 1 | Threshold reached |
| tmo_pend | output | 1 | Character timeout pending |
| rx_level | output | $clog2(DEPTH)+1 | Number of stored bytes |
| ctrl_val | output | 8 | Held control value |
| tx_flush | output | 1 | Transmit queue flush pulse |

## Verification
The bench fills the queue and pushes one byte past it. A design that overwrote on overrun would then return the extra byte in place of the sixteenth, or count past 16. It counts the timeout to the exact cycle, both from a received byte and from a read that leaves data behind. A timer that was not restarted, or that was off by one, fires a cycle early or late. It also checks that an empty queue never gets a timeout. It checks that rewriting the same control value neither flushes nor pulses, and that flipping the enable bit always does. It walks all four thresholds one byte below and at each level. A break followed by reads checks that the break flag lasts until the queue empties.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int CT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  input  logic [7:0]                  rx_byte,
  input  logic                        rx_break,
  input  logic                        fcr_we,
  input  logic [7:0]                  fcr_wdata,
  input  logic                        rbr_rd,
  input  logic                        lsr_rd,
  input  logic [CT_W-1:0]             char_time,
  output logic [7:0]                  rd_data,
  output logic                        data_ready,
  output logic                        overrun_err,
  output logic                        break_seen,
  output logic                        trig_hit,
  output logic                        tmo_pend,
  output logic [$clog2(DEPTH):0]      rx_level,
  output logic [7:0]                  ctrl_val,
  output logic                        tx_flush
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = CT_W + 2;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    ctrl_q, hold_q;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, lvl;
  logic          dr_q, oe_q, bi_q, tmo_q, txf_q, trun;
  logic [TW-1:0] tcnt;

  wire fen      = ctrl_q[0];
  wire ctl_hit  = fcr_we && (fcr_wdata != ctrl_q);
  wire en_flip  = ctl_hit && (fcr_wdata[0] ^ ctrl_q[0]);
  wire rx_clr   = ctl_hit && (fcr_wdata[1] || en_flip);
  wire push     = (rx_valid || rx_break) && !rx_clr;
  wire [7:0] pbyte = rx_break ? 8'h00 : rx_byte;
  wire f_pop    = fen && rbr_rd && (cnt != '0) && !rx_clr;
  wire f_push   = fen && push && (cnt != FULL);
  wire f_ovr    = fen && push && (cnt == FULL);
  wire empty_rd = fen ? (f_pop && cnt == CW'(1) && !push) : (rbr_rd && !push && !rx_clr);
  wire restart  = fen && !rx_clr && (push || (f_pop && cnt > CW'(1)));
  wire [TW-1:0] load = {char_time, 2'b00};

  always_comb begin
    case (ctrl_q[7:6])
      2'b00:   lvl = CW'(1);
      2'b01:   lvl = CW'(4);
      2'b10:   lvl = CW'(8);
      default: lvl = CW'(14);
    endcase
  end

  always_ff @(posedge clk) begin
    if (f_push) mem[wp] <= pbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; txf_q <= 1'b0;
      wp <= '0; rp <= '0; cnt <= '0; hold_q <= '0;
    end else begin
      txf_q <= ctl_hit && (fcr_wdata[2] || en_flip);
      if (ctl_hit) ctrl_q <= fcr_wdata & 8'hC9;
      if (rx_clr) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (f_push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
        if (f_pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
        if (f_push && !f_pop)      cnt <= cnt + CW'(1);
        else if (f_pop && !f_push) cnt <= cnt - CW'(1);
      end
      if (!fen && push) hold_q <= pbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= 1'b0; oe_q <= 1'b0; bi_q <= 1'b0;
    end else begin
      if (rx_clr)        dr_q <= 1'b0;
      else if (push)     dr_q <= 1'b1;
      else if (empty_rd) dr_q <= 1'b0;

      if (rx_clr)                        bi_q <= 1'b0;
      else if (rx_break)                 bi_q <= 1'b1;
      else if (lsr_rd || empty_rd)       bi_q <= 1'b0;

      if (f_ovr || (!fen && push && dr_q)) oe_q <= 1'b1;
      else if (lsr_rd)                     oe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trun <= 1'b0; tcnt <= '0; tmo_q <= 1'b0;
    end else begin
      if (rx_clr) trun <= 1'b0;
      else if (restart) begin
        trun <= (load != '0);
        tcnt <= load;
      end else if (trun) begin
        tcnt <= tcnt - TW'(1);
        if (tcnt == TW'(1)) trun <= 1'b0;
      end

      if (rx_clr || (fen && rbr_rd)) tmo_q <= 1'b0;
      else if (trun && tcnt == TW'(1) && !restart && cnt != '0) tmo_q <= 1'b1;
    end
  end

  assign rd_data     = fen ? ((cnt != '0) ? mem[rp] : 8'h00) : hold_q;
  assign data_ready  = dr_q;
  assign overrun_err = oe_q;
  assign break_seen  = bi_q;
  assign trig_hit    = dr_q && (!fen || cnt >= lvl);
  assign tmo_pend    = tmo_q;
  assign rx_level    = cnt;
  assign ctrl_val    = ctrl_q;
  assign tx_flush    = txf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R2
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (f_ovr && !rbr_rd) |=> (oe_q && cnt == FULL && $stable(rd_data))); // R3
  AST_SAME_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fcr_wdata == ctrl_q) |=> (!tx_flush && $stable(ctrl_q))); // R5
  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> (cnt != '0)); // R7
  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !rx_clr) |=> (bi_q && dr_q)); // R9
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_valid && !rx_break) |=> (!bi_q && !oe_q)); // R10
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && rbr_rd && cnt == '0 && !push && !rx_clr) |=> (cnt == '0 && $stable(rp))); // R12
endmodule

// File: tb/uart_rx_queue_tb_top.sv
`timescale 1ns/1ps
module uart_rx_queue_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_break = 0, fcr_we = 0, rbr_rd = 0, lsr_rd = 0;
  logic [7:0] rx_byte = 0, fcr_wdata = 0;
  logic [15:0] char_time = 16'd5;
  logic [7:0] rd_data, ctrl_val;
  logic data_ready, overrun_err, break_seen, trig_hit, tmo_pend, tx_flush;
  logic [4:0] rx_level;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_queue dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_break(rx_break), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .char_time(char_time),
    .rd_data(rd_data), .data_ready(data_ready), .overrun_err(overrun_err),
    .break_seen(break_seen), .trig_hit(trig_hit), .tmo_pend(tmo_pend),
    .rx_level(rx_level), .ctrl_val(ctrl_val), .tx_flush(tx_flush));

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); fcr_we = 1; fcr_wdata = v;
    @(negedge clk); fcr_we = 0;
  endtask
  task automatic push_b(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask
  task automatic brk();
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
  endtask
  task automatic rd_buf(output logic [7:0] v);
    @(negedge clk); v = rd_data; rbr_rd = 1;
    @(negedge clk); rbr_rd = 0;
  endtask
  task automatic rd_stat();
    @(negedge clk); lsr_rd = 1;
    @(negedge clk); lsr_rd = 0;
  endtask

  task automatic t_reset();
    chk("R1 level", rx_level, 0);
    chk("R1 flags", {data_ready, overrun_err, break_seen, tmo_pend, trig_hit, tx_flush}, 0);
    chk("R1 ctrl", ctrl_val, 8'h00);
  endtask

  task automatic t_order();
    logic [7:0] v;
    wr_ctrl(8'h01);
    chk("R6 flush pulse on enable", tx_flush, 1);
    chk("R5 retained", ctrl_val, 8'h01);
    for (int i = 0; i < 16; i++) push_b(8'(8'h10 + i * 3));
    chk("R2 level 16", rx_level, 16);
    for (int i = 0; i < 16; i++) begin
      rd_buf(v);
      chk("R2 order", v, 8'(8'h10 + i * 3));
    end
    chk("R8 dr cleared on empty", data_ready, 0);
  endtask

  task automatic t_trigger();
    int lv[4] = '{1, 4, 8, 14};
    for (int c = 0; c < 4; c++) begin
      wr_ctrl({2'(c), 6'b000011});
      chk("R5 rx clear", rx_level, 0);
      chk("R5 mask", ctrl_val, {2'(c), 6'b000001});
      for (int k = 0; k < lv[c] - 1; k++) push_b(8'(k));
      chk("R4 below threshold", trig_hit, 0);
      push_b(8'hA5);
      chk("R4 at threshold", trig_hit, 1);
    end
  endtask

  task automatic t_ctrl_writes();
    wr_ctrl(8'hC1);
    chk("R5 same value keeps data", rx_level, 14);
    chk("R5 same value no pulse", tx_flush, 0);
    wr_ctrl(8'hC5);
    chk("R5 tx reset pulse", tx_flush, 1);
    chk("R5 tx reset keeps rx", rx_level, 14);
    chk("R5 bit2 not retained", ctrl_val, 8'hC1);
    wr_ctrl(8'hC0);
    chk("R6 disable flushes rx", rx_level, 0);
    chk("R6 disable clears dr", data_ready, 0);
    chk("R6 disable pulses tx", tx_flush, 1);
  endtask

  task automatic t_holding();
    logic [7:0] v;
    push_b(8'h11);
    chk("R11 dr", data_ready, 1);
    chk("R11 data", rd_data, 8'h11);
    chk("R4 trig follows dr when off", trig_hit, 1);
    push_b(8'h22);
    chk("R11 overrun", overrun_err, 1);
    chk("R11 newest kept", rd_data, 8'h22);
    rd_buf(v);
    chk("R11 read value", v, 8'h22);
    chk("R11 read clears dr", data_ready, 0);
    rd_stat();
    chk("R10 oe cleared", overrun_err, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    wr_ctrl(8'h01);
    for (int i = 0; i < 16; i++) push_b(8'(8'h40 + i));
    push_b(8'hEE);
    chk("R3 overrun flag", overrun_err, 1);
    chk("R3 level stays 16", rx_level, 16);
    for (int i = 0; i < 16; i++) begin
      rd_buf(v);
      chk("R3 contents kept", v, 8'(8'h40 + i));
    end
    rd_stat();
    chk("R10 overrun cleared", overrun_err, 0);
    rd_buf(v);
    chk("R12 empty read value", v, 8'h00);
    chk("R12 empty read level", rx_level, 0);
  endtask

  task automatic t_break();
    logic [7:0] v;
    push_b(8'h55);
    brk();
    chk("R9 level", rx_level, 2);
    chk("R9 flags", {break_seen, data_ready}, 2'b11);
    rd_buf(v);
    chk("R2 first", v, 8'h55);
    chk("R8 break held while data", break_seen, 1);
    rd_buf(v);
    chk("R9 zero byte", v, 8'h00);
    chk("R8 empty clears", {break_seen, data_ready}, 2'b00);
    brk();
    rd_stat();
    chk("R10 break cleared", break_seen, 0);
    chk("R10 dr kept", data_ready, 1);
    rd_buf(v);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    char_time = 16'd5;
    wr_ctrl(8'h03);
    push_b(8'h77);
    repeat (19) @(negedge clk);
    chk("R7 not yet", tmo_pend, 0);
    @(negedge clk);
    chk("R7 fires at 4 chars", tmo_pend, 1);
    push_b(8'h78);
    chk("R7 push keeps pending", tmo_pend, 1);
    rd_buf(v);
    chk("R7 read clears", tmo_pend, 0);
    repeat (19) @(negedge clk);
    chk("R7 restart by read", tmo_pend, 0);
    @(negedge clk);
    chk("R7 fires after read", tmo_pend, 1);
    rd_buf(v);
    chk("R7 cleared on emptying read", tmo_pend, 0);
    repeat (30) @(negedge clk);
    chk("R7 no data no timeout", tmo_pend, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_ctrl_writes();
    t_holding();
    t_overrun();
    t_break();
    t_timeout();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule